// File: doc/BRIEF.md
# Pipelined Instruction Fetch Unit

This block owns the program counter of a five-stage in-order pipeline. In every cycle it presents the current PC as the instruction memory address. On the next edge it captures the returned word, together with the incremented PC, into the fetch/decode pipeline register. Unless a taken branch redirects it, the PC then moves on by one word (4 bytes).

Branches resolve late. The block contains a dedicated target adder that the execute stage uses. The adder takes the incremented PC carried by the branch and its 16-bit offset, sign-extends the offset and scales it by four. The pipeline stores that target and the comparison outcome in its execute/memory register. From the memory stage it drives the taken strobe and the stored target back into this block. The target is therefore loaded three sequential fetches after the branch word. Those three fetches are never cancelled: they stay in the pipeline.

Top module: `fetch_unit`

## Requirements
- R1: The instruction address output always equals the PC. A synchronous active-high reset loads the PC with 0 and clears both fetch/decode outputs to all zeros.
- R2: On each clock edge without reset and without a taken branch, the PC advances by exactly 4.
- R3: On the same edge that updates the PC, the fetch/decode register captures the instruction word presented in that cycle and the value PC+4 of that cycle.
- R4: When the taken strobe is high on an edge, the PC loads the supplied branch target instead of PC+4. The target wins over the sequential increment. A reset on the same edge wins over both.
- R5: The target adder output is combinational and equals the execute-stage PC+4 plus the sign-extended 16-bit offset shifted left by two. Negative offsets move the target backwards.
- R6: Fetches made between a branch and its redirect are not cancelled. Each of them still reaches the fetch/decode outputs with its own word and address.
- R7: Suppose a branch at address 12 is fetched in cycle 4, with its target computed in execute and applied from the memory stage. The sequential words at 16, 20 and 24 are then fetched in cycles 5 to 7, and the address in cycle 8 is the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imemAddr | output | 32 | Instruction memory address (current PC) |
| imemData | input | 32 | Instruction word for imemAddr, valid in the same cycle |
| brTaken | input | 1 | Memory-stage taken strobe (stored branch control AND zero flag) |
| brTarget | input | 32 | Memory-stage stored branch target |
| exPcPlus4 | input | 32 | Execute-stage incremented PC of the branch |
| exImm | input | 16 | Execute-stage branch offset in words |
| exTarget | output | 32 | Target adder result for the execute stage |
| ifInstr | output | 32 | Fetch/decode register: instruction word |
| ifPcPlus4 | output | 32 | Fetch/decode register: PC+4 of that word |

## Verification
The address output and the target adder are combinational, so they are checked within the cycle in which their inputs are driven. The PC, the captured word and the captured PC+4 are due one edge after the cycle that produced them. The bench drives inputs away from the edge and advances one rising edge plus a small delay before it samples. It predicts each registered value from the address and the word of the previous cycle. The branch scenario counts edges from the fetch of the branch word: the redirect takes effect after the third sequential fetch, and the target is fetched in the fourth cycle.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  // Strobes issued by the fetch control to the fetch datapath.
  typedef struct packed {
    logic clearAll;    // synchronous reset of PC and fetch/decode register
    logic takeTarget;  // load the branch target instead of PC+step
  } fetchCtrl_t;
endpackage

// File: rtl/fetch_target_adder.sv
module fetch_target_adder #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [ADDR_W-1:0] basePc,
  input  logic [IMM_W-1:0]  wordOffset,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] extOffset;

  always_comb begin
    extOffset = {{EXT_W{wordOffset[IMM_W-1]}}, wordOffset};
    target    = basePc + (extOffset << 2);
  end
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       brTaken,
  output fetchCtrl_t ctrl
);
  always_comb begin
    ctrl.clearAll   = rst;
    ctrl.takeTarget = brTaken && !rst;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk)
    $onehot0({ctrl.clearAll, ctrl.takeTarget})); // R4
endmodule

// File: rtl/fetch_datapath.sv
module fetch_datapath
  import fetch_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int INSTR_W  = 32,
  parameter int PC_STEP  = 4,
  parameter int RESET_PC = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  fetchCtrl_t         ctrl,
  input  logic [ADDR_W-1:0]  brTarget,
  input  logic [INSTR_W-1:0] imemData,
  output logic [ADDR_W-1:0]  pcOut,
  output logic [INSTR_W-1:0] ifInstr,
  output logic [ADDR_W-1:0]  ifPcPlus4
);
  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(PC_STEP);
  localparam logic [ADDR_W-1:0] PC_INIT = ADDR_W'(RESET_PC);

  logic [ADDR_W-1:0]  pcQ;
  logic [ADDR_W-1:0]  pcInc;
  logic [ADDR_W-1:0]  pcNext;
  logic [INSTR_W-1:0] instrQ;
  logic [ADDR_W-1:0]  incQ;

  always_comb begin
    pcInc  = pcQ + STEP;
    pcNext = ctrl.takeTarget ? brTarget : pcInc;
  end

  always_ff @(posedge clk) begin
    if (ctrl.clearAll) begin
      pcQ    <= PC_INIT;
      instrQ <= '0;
      incQ   <= '0;
    end else begin
      pcQ    <= pcNext;
      instrQ <= imemData;
      incQ   <= pcInc;
    end
  end

  assign pcOut     = pcQ;
  assign ifInstr   = instrQ;
  assign ifPcPlus4 = incQ;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (pcOut == PC_INIT && ifInstr == '0 && ifPcPlus4 == '0)); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    !ctrl.takeTarget |=> pcOut == $past(pcOut) + STEP); // R2
  AST_IFID_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (ifInstr == $past(imemData) && ifPcPlus4 == $past(pcOut) + STEP)); // R3
  AST_PC_TARGET: assert property (@(posedge clk) disable iff (rst)
    ctrl.takeTarget |=> pcOut == $past(brTarget)); // R4
endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
  import fetch_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int INSTR_W  = 32,
  parameter int IMM_W    = 16,
  parameter int PC_STEP  = 4,
  parameter int RESET_PC = 0
) (
  input  logic               clk,
  input  logic               rst,
  output logic [ADDR_W-1:0]  imemAddr,
  input  logic [INSTR_W-1:0] imemData,
  input  logic               brTaken,
  input  logic [ADDR_W-1:0]  brTarget,
  input  logic [ADDR_W-1:0]  exPcPlus4,
  input  logic [IMM_W-1:0]   exImm,
  output logic [ADDR_W-1:0]  exTarget,
  output logic [INSTR_W-1:0] ifInstr,
  output logic [ADDR_W-1:0]  ifPcPlus4
);
  fetchCtrl_t ctrl;

  fetch_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .brTaken (brTaken),
    .ctrl    (ctrl)
  );

  fetch_datapath #(
    .ADDR_W   (ADDR_W),
    .INSTR_W  (INSTR_W),
    .PC_STEP  (PC_STEP),
    .RESET_PC (RESET_PC)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .brTarget  (brTarget),
    .imemData  (imemData),
    .pcOut     (imemAddr),
    .ifInstr   (ifInstr),
    .ifPcPlus4 (ifPcPlus4)
  );

  fetch_target_adder #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W)
  ) u_tgt (
    .basePc     (exPcPlus4),
    .wordOffset (exImm),
    .target     (exTarget)
  );
endmodule

// File: tb/fetch_unit_tb.sv
module fetch_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imemAddr;
  logic [31:0] imemData;
  logic        brTaken = 1'b0;
  logic [31:0] brTarget = '0;
  logic [31:0] exPcPlus4 = '0;
  logic [15:0] exImm = '0;
  logic [31:0] exTarget;
  logic [31:0] ifInstr;
  logic [31:0] ifPcPlus4;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  // Bench instruction memory: word derived from the address.
  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction
  assign imemData = memWord(imemAddr);

  fetch_unit u_dut (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .brTaken(brTaken), .brTarget(brTarget), .exPcPlus4(exPcPlus4),
    .exImm(exImm), .exTarget(exTarget), .ifInstr(ifInstr), .ifPcPlus4(ifPcPlus4)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // R1: reset state
  task automatic t_reset();
    rst = 1'b1;
    tick(); tick();
    check("R1 pc", imemAddr, 32'd0);
    check("R1 instr", ifInstr, 32'd0);
    check("R1 pc4", ifPcPlus4, 32'd0);
    rst = 1'b0;
  endtask

  // R2 R3: sequential fetch
  task automatic t_sequential();
    logic [31:0] prev;
    for (int i = 0; i < 6; i++) begin
      prev = imemAddr;
      check("R1 addr", imemAddr, prev);
      tick();
      check("R2 step", imemAddr, prev + 32'd4);
      check("R3 instr", ifInstr, memWord(prev));
      check("R3 pc4", ifPcPlus4, prev + 32'd4);
    end
  endtask

  // R5: target adder
  task automatic t_adder();
    exPcPlus4 = 32'd16; exImm = 16'd246; #1;
    check("R5 pos", exTarget, 32'd1000);
    exPcPlus4 = 32'h100; exImm = 16'hFFFE; #1;
    check("R5 neg", exTarget, 32'hF8);
    exPcPlus4 = 32'h0; exImm = 16'h8000; #1;
    check("R5 min", exTarget, 32'hFFFE_0000);
  endtask

  // R4 R6 R7: late branch, fetched at 12 in cycle 4
  task automatic t_branch();
    logic [31:0] capTarget;
    rst = 1'b1; tick(); rst = 1'b0;      // cycle 1 fetches 0
    tick(); tick(); tick();              // now cycle 4
    check("R7 c4", imemAddr, 32'd12);
    tick();                              // cycle 5: branch in decode
    check("R7 c5", imemAddr, 32'd16);
    check("R6 id", ifInstr, memWord(32'd12));
    exPcPlus4 = ifPcPlus4; exImm = 16'd246;
    tick();                              // cycle 6: branch in execute
    check("R7 c6", imemAddr, 32'd20);
    check("R5 ex", exTarget, 32'd1000);
    capTarget = exTarget;
    tick();                              // cycle 7: memory stage
    check("R7 c7", imemAddr, 32'd24);
    brTaken = 1'b1; brTarget = capTarget;
    tick();                              // cycle 8
    brTaken = 1'b0;
    check("R4 redirect", imemAddr, 32'd1000);
    check("R6 kept", ifInstr, memWord(32'd24));
    check("R6 pc4", ifPcPlus4, 32'd28);
    tick();
    check("R2 after", imemAddr, 32'd1004);
    check("R3 target word", ifInstr, memWord(32'd1000));
  endtask

  // R4: back-to-back taken, then reset wins over taken
  task automatic t_priority();
    brTaken = 1'b1; brTarget = 32'h40;
    tick();
    check("R4 first", imemAddr, 32'h40);
    brTarget = 32'h80;
    tick();
    check("R4 second", imemAddr, 32'h80);
    rst = 1'b1; brTarget = 32'hC0;
    tick();
    check("R4 reset wins", imemAddr, 32'd0);
    check("R1 midrun clr", ifInstr, 32'd0);
    rst = 1'b0; brTaken = 1'b0;
    tick();
    check("R2 post", imemAddr, 32'd4);
  endtask

  initial begin
    t_reset();
    t_sequential();
    t_adder();
    t_branch();
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule